// File: doc/BRIEF.md
# RGBI Hold-and-Modify Pair Decoder

This block takes a 4-bit digital RGBI pixel stream and turns it into 18-bit colour, with six bits for each of red, green and blue. Inside a qualified region, two consecutive pixels are read together as one control unit. That unit holds a 6-bit level and a 2-bit operation code. The code chooses which component of the held colour takes the new level. Because there is no palette, every colour comes from changing the colour before it, one component at a time.

The region is marked by the horizontal and vertical sync inputs being asserted in the same pixel clock. Outside the region, each pixel goes straight through, widened to 18 bits. Each decoded colour stays on the output for two pixel clocks, which is the width of the pair it came from. The held colour is cleared to black every time the region opens.

Top module: `hamrgbi_pair_decoder`

## Requirements
- R1: While rst_n is low, rgb_out is 0 and out_valid is 0.
- R2: When decode is disabled, rgb_out one clock later is the current pixel widened as {c,c,i,i,i,i} for each channel. Here rgbi[3]=r, rgbi[2]=g, rgbi[1]=b and rgbi[0]=i, and rgb_out[17:12]=red, [11:6]=green, [5:0]=blue. out_valid is 1 in that case.
- R3: Decode is enabled only in a clock where hsync and vsync are both high. With either one low, the pass-through of R2 applies.
- R4: In the first enabled clock after a disabled clock, the held colour is cleared and that pixel is taken as the first of a pair. On the next clock, rgb_out is 0 and out_valid is 0.
- R5: For a pair with first pixel p1 and second pixel p2, the level is {p2.b, p2.i, p1.r, p1.g, p1.b, p1.i} (MSB first), and the code is {p2.r, p2.g}.
- R6: Code 01 replaces blue, code 10 replaces red and code 11 replaces green. The other two components keep their held values.
- R7: Code 00 loads the level into all three components, which gives a grey.
- R8: On the clock after the first pixel of a pair that is not at the start of the region, rgb_out is unchanged and out_valid is 1. Each decoded colour is therefore shown for two clocks.
- R9: A decoded colour appears on rgb_out on the clock edge right after the second pixel of its pair is sampled.
- R10: If the enable drops after the first pixel of a pair, that pixel is discarded. When the enable returns, the pair phase and the held colour start again as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rgbi | input | 4 | Pixel: r, g, b, i from bit 3 down to bit 0 |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| rgb_out | output | 18 | Red, green, blue, six bits each |
| out_valid | output | 1 | Low only for the clock after a region start or during reset |

## Verification
Two functions can land in the same clock: clearing the held colour when the region opens, and pair assembly carrying on from an earlier enabled stretch. The bench provokes this by dropping hsync for exactly one clock after the first pixel of a pair, then asserting both syncs again. At that moment the pending pixel must be thrown away, the phase must restart and the colour must return to black, while the clock in between still passes its pixel through. The behavioural model in the bench predicts the output on every clock, and any mismatch in colour or out_valid is reported against the requirement that governs that clock.

// File: rtl/hamrgbi_pair_decoder.sv
module hamrgbi_pair_decoder #(
  parameter bit SYNC_LEVEL = 1'b1
) (
  input  logic        pix_clk,
  input  logic        rst_n,
  input  logic [3:0]  rgbi,
  input  logic        hsync,
  input  logic        vsync,
  output logic [17:0] rgb_out,
  output logic        out_valid
);

  logic       en, en_d, phase, line_start;
  logic [3:0] first;
  logic [5:0] hr, hg, hb;
  logic [5:0] nr, ng, nb;
  logic [5:0] level;
  logic [1:0] code;

  assign en         = (hsync == SYNC_LEVEL) && (vsync == SYNC_LEVEL);
  assign line_start = en && !en_d;
  assign level      = {rgbi[1], rgbi[0], first};
  assign code       = rgbi[3:2];

  function automatic logic [5:0] widen(input logic c, input logic i);
    return {c, c, i, i, i, i};
  endfunction

  always_comb begin
    nr = hr;
    ng = hg;
    nb = hb;
    case (code)
      2'b00: begin nr = level; ng = level; nb = level; end
      2'b01: nb = level;
      2'b10: nr = level;
      default: ng = level;
    endcase
  end

  always_ff @(posedge pix_clk) begin
    if (!rst_n) begin
      en_d      <= 1'b0;
      phase     <= 1'b0;
      first     <= '0;
      hr        <= '0;
      hg        <= '0;
      hb        <= '0;
      rgb_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      en_d <= en;
      if (!en) begin
        phase     <= 1'b0;
        rgb_out   <= {widen(rgbi[3], rgbi[0]), widen(rgbi[2], rgbi[0]), widen(rgbi[1], rgbi[0])};
        out_valid <= 1'b1;
      end else if (line_start) begin
        hr        <= '0;
        hg        <= '0;
        hb        <= '0;
        first     <= rgbi;
        phase     <= 1'b1;
        rgb_out   <= '0;
        out_valid <= 1'b0;
      end else if (!phase) begin
        first     <= rgbi;
        phase     <= 1'b1;
        out_valid <= 1'b1;
      end else begin
        hr        <= nr;
        hg        <= ng;
        hb        <= nb;
        rgb_out   <= {nr, ng, nb};
        phase     <= 1'b0;
        out_valid <= 1'b1;
      end
    end
  end

  AST_PASS_WIDEN: assert property (@(posedge pix_clk) disable iff (!rst_n)
    !en |=> (out_valid && rgb_out[17:16] == {2{$past(rgbi[3])}} && rgb_out[3:0] == {4{$past(rgbi[0])}})); // R2

  AST_REGION_CLEAR: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (en && !en_d) |=> (rgb_out == 18'd0 && !out_valid)); // R4

  AST_PAIR_HOLD: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (en && en_d && !phase) |=> ($stable(rgb_out) && out_valid)); // R8

  AST_BLUE_ONLY: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (en && en_d && phase && code == 2'b01) |=> (rgb_out[17:6] == $past(rgb_out[17:6]) && rgb_out[5:0] == $past(level))); // R6

  AST_GREY_LOAD: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (en && en_d && phase && code == 2'b00) |=> (rgb_out[17:12] == rgb_out[11:6] && rgb_out[11:6] == rgb_out[5:0])); // R7

endmodule

// File: tb/tb_hamrgbi_pair_decoder.sv
module tb_hamrgbi_pair_decoder;
  logic        pix_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rgbi = 4'd0;
  logic        hsync = 1'b0;
  logic        vsync = 1'b0;
  logic [17:0] rgb_out;
  logic        out_valid;

  int checks = 0;
  int failures = 0;

  int m_r = 0, m_g = 0, m_b = 0;
  int m_ph = 0, m_prev = 0, m_first = 0;
  int exp_col = 0, exp_v = 0;

  always #4 pix_clk = ~pix_clk;

  hamrgbi_pair_decoder dut (
    .pix_clk(pix_clk), .rst_n(rst_n), .rgbi(rgbi), .hsync(hsync),
    .vsync(vsync), .rgb_out(rgb_out), .out_valid(out_valid)
  );

  function automatic int chan(int c, int i);
    return (c != 0 ? 48 : 0) + (i != 0 ? 15 : 0);
  endfunction

  task automatic compare(string tag);
    checks++;
    if (rgb_out !== exp_col[17:0] || out_valid !== exp_v[0]) begin
      failures++;
      $display("FAIL %s rgb_out=%h valid=%b expected rgb_out=%h valid=%0d",
               tag, rgb_out, out_valid, exp_col[17:0], exp_v);
    end
  endtask

  task automatic step(input int pix, input int hs, input int vs, input string tag);
    int en, r, g, b, i, lvl, code;
    @(negedge pix_clk);
    rgbi = pix[3:0]; hsync = hs[0]; vsync = vs[0];
    en = hs & vs;
    r = (pix >> 3) & 1; g = (pix >> 2) & 1; b = (pix >> 1) & 1; i = pix & 1;
    if (en == 0) begin
      exp_col = chan(r, i) * 4096 + chan(g, i) * 64 + chan(b, i);
      exp_v = 1; m_ph = 0;
    end else if (m_prev == 0) begin
      m_r = 0; m_g = 0; m_b = 0; m_first = pix; m_ph = 1;
      exp_col = 0; exp_v = 0;
    end else if (m_ph == 0) begin
      m_first = pix; m_ph = 1; exp_v = 1;
    end else begin
      lvl = b * 32 + i * 16 + m_first;
      code = r * 2 + g;
      case (code)
        0: begin m_r = lvl; m_g = lvl; m_b = lvl; end
        1: m_b = lvl;
        2: m_r = lvl;
        default: m_g = lvl;
      endcase
      exp_col = m_r * 4096 + m_g * 64 + m_b;
      exp_v = 1; m_ph = 0;
    end
    m_prev = en;
    @(posedge pix_clk);
    #1;
    compare(tag);
  endtask

  task automatic pair(input int p1, input int p2, input string tag);
    step(p1, 1, 1, "R8");
    step(p2, 1, 1, tag);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge pix_clk);
    #1;
    exp_col = 0; exp_v = 0;
    compare("R1");
    @(negedge pix_clk);
    rst_n = 1'b1;

    for (int k = 0; k < 16; k++) step(k, 0, 0, "R2");
    step(4'hA, 1, 0, "R3");
    step(4'h5, 0, 1, "R3");
    step(4'hF, 1, 0, "R3");

    step(4'b1010, 1, 1, "R4");
    step(4'b0111, 1, 1, "R5 R9");
    pair(4'b0011, 4'b1011, "R6");
    pair(4'b1100, 4'b1110, "R6");
    pair(4'b0110, 4'b0000, "R7");
    pair(4'b1111, 4'b0011, "R7");
    pair(4'b0101, 4'b0110, "R6");

    step(4'b1001, 1, 1, "R8");
    step(4'h3, 0, 1, "R10");
    step(4'b0110, 1, 1, "R10");
    step(4'b1101, 1, 1, "R10");
    step(4'h2, 1, 1, "R8");

    for (int line = 0; line < 40; line++) begin
      for (int k = 0; k < 6; k++) step(int'($urandom_range(0, 15)), 0, int'($urandom_range(0, 1)), "R3");
      step(int'($urandom_range(0, 15)), 1, 1, "R4");
      for (int k = 0; k < 40; k++) step(int'($urandom_range(0, 15)), 1, 1, "R6");
      if (line % 3 == 0) begin
        step(int'($urandom_range(0, 15)), 0, 1, "R10");
        step(int'($urandom_range(0, 15)), 1, 1, "R10");
        step(int'($urandom_range(0, 15)), 1, 1, "R10");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule